// File: doc/BRIEF.md
# Clock Output Mode Controller

This block is the digital control that decides what reaches a complementary clock output pair. Three clock pairs arrive at its inputs: a phase-aligned pair, a full-speed PLL pair and a reference pair. A two-bit source code picks among these. The same code also has a setting that three-states both outputs for component and board testing. Two active-low controls sit above the source code. Power-down has the highest priority: it turns the outputs off, three-states them and disables the PLL. Clock stop comes next: it parks both outputs at one common level.

The source code is held in a register. That register follows the select pins only while power-down is asserted, so the select pins may be changed only while the part is powered off. The operating state (run, stop or off) is registered from the two control inputs on every clock edge. The output pair, the two output enables and the PLL enable are decoded from the registered state and the registered source code. Clock inputs pass straight through to the outputs without a register. The block makes no attempt to switch without glitches when the state changes.

Top module: `clkmode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the state register becomes off (`state_o`=2'b10) and the source code register becomes 2'b00. From that edge on, both output enables and `pll_en` are 0 and both outputs are 0.
- R2: At a rising edge of `clk` where `pwrdn_n`=0, the source code register loads `sel`. At an edge where `pwrdn_n`=1, it keeps its value, and a change on `sel` has no effect on any output.
- R3: At each rising edge the state register loads off (2'b10) if `pwrdn_n`=0. Otherwise it loads stop (2'b01) if `stop_n`=0, and otherwise run (2'b00). The value 2'b11 never appears.
- R4: In run state with code 2'b00, `clk_o`/`clkb_o` follow `pa_clk`/`pa_clkb`, both enables are 1 and `pll_en` is 1.
- R5: In run state with code 2'b01, both enables are 0, both outputs are 0 and `pll_en` is 1.
- R6: In run state with code 2'b10, the outputs follow `pll_clk`/`pll_clkb`, both enables are 1 and `pll_en` is 1.
- R7: In run state with code 2'b11, the outputs follow `ref_clk`/`ref_clkb`, both enables are 1 and `pll_en` is 0.
- R8: In off state, both enables are 0, both outputs are 0 and `pll_en` is 0, whatever the source code and the clock inputs.
- R9: In stop state, both outputs equal the parked level `PARK_LVL` (default 0) and both enables are 1, for every source code. `pll_en` is 0 for code 2'b11 and 1 for the other codes.
- R10: The clock outputs respond to the selected clock inputs without any register delay, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_clk | input | 1 | Phase-aligned clock, true side |
| pa_clkb | input | 1 | Phase-aligned clock, complement side |
| pll_clk | input | 1 | Full-speed PLL clock, true side |
| pll_clkb | input | 1 | Full-speed PLL clock, complement side |
| ref_clk | input | 1 | Reference clock, true side |
| ref_clkb | input | 1 | Reference clock, complement side |
| sel | input | 2 | Source code, captured only in power-down |
| pwrdn_n | input | 1 | Active-low power-down |
| stop_n | input | 1 | Active-low clock stop |
| clk_o | output | 1 | Output clock, true side |
| clkb_o | output | 1 | Output clock, complement side |
| clk_oe | output | 1 | Enable for the true-side driver |
| clkb_oe | output | 1 | Enable for the complement-side driver |
| pll_en | output | 1 | PLL enable |
| state_o | output | 2 | Operating state: 00 run, 01 stop, 10 off |

## Verification
A change on `pwrdn_n`, `stop_n` or `sel` shows up at the outputs only after the next rising edge, because exactly one register stage lies between these inputs and every output. The bench therefore drives control inputs at the falling edge and samples 2 ns after the following rising edge. A change on any clock input must show up within the same cycle. After each state update, the bench steps through all 64 combinations of the six clock inputs and checks each one 1 ns after applying it, without waiting for an edge. The bench holds control inputs steady throughout each sweep, so any edge that occurs during a sweep reloads the same values.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int SEL_W   = 2;
    localparam int STATE_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_ALIGNED = 2'b00,
        SRC_HIZ     = 2'b01,
        SRC_PLL     = 2'b10,
        SRC_REF     = 2'b11
    } src_mode_e;

    typedef enum logic [STATE_W-1:0] {
        ST_RUN  = 2'b00,
        ST_STOP = 2'b01,
        ST_OFF  = 2'b10
    } op_state_e;

    typedef struct packed {
        logic p;
        logic n;
    } clk_pair_t;

    typedef struct packed {
        clk_pair_t lvl;
        logic      oe_p;
        logic      oe_n;
        logic      pll_on;
    } drive_t;

    function automatic op_state_e pick_state(input logic pwr_n, input logic halt_n);
        if (!pwr_n)       return ST_OFF;
        else if (!halt_n) return ST_STOP;
        else              return ST_RUN;
    endfunction

    function automatic logic pll_wanted(input op_state_e st, input src_mode_e md);
        return (st != ST_OFF) && (md != SRC_REF);
    endfunction

endpackage

// File: rtl/clkmode_state.sv
module clkmode_state
    import clkmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_n,
    input  logic      halt_n,
    output op_state_e state_q
);

    op_state_e state_d;

    always_comb begin
        state_d = pick_state(pwr_n, halt_n);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    AST_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
        !pwr_n |=> state_q == ST_OFF); // R3

    AST_STOP_NEXT: assert property (@(posedge clk) disable iff (rst)
        (pwr_n && !halt_n) |=> state_q == ST_STOP); // R3

    AST_RUN_NEXT: assert property (@(posedge clk) disable iff (rst)
        (pwr_n && halt_n) |=> state_q == ST_RUN); // R3

endmodule

// File: rtl/clkmode_selreg.sv
module clkmode_selreg
    import clkmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [SEL_W-1:0] sel_i,
    output src_mode_e        mode_q
);

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= SRC_ALIGNED;
        else if (load_en) mode_q <= src_mode_e'(sel_i);
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(mode_q)); // R2

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_en |=> mode_q == $past(sel_i)); // R2

endmodule

// File: rtl/clkmode_outmux.sv
module clkmode_outmux
    import clkmode_pkg::*;
#(
    parameter logic PARK_LVL = 1'b0
) (
    input  op_state_e st,
    input  src_mode_e md,
    input  clk_pair_t pa,
    input  clk_pair_t pll,
    input  clk_pair_t refc,
    output drive_t    drv
);

    clk_pair_t run_lvl;
    logic      run_oe;

    always_comb begin
        run_oe = 1'b1;
        unique case (md)
            SRC_ALIGNED: run_lvl = pa;
            SRC_PLL:     run_lvl = pll;
            SRC_REF:     run_lvl = refc;
            default: begin
                run_lvl = '0;
                run_oe  = 1'b0;
            end
        endcase
    end

    always_comb begin
        drv.pll_on = pll_wanted(st, md);
        unique case (st)
            ST_OFF: begin
                drv.lvl  = '0;
                drv.oe_p = 1'b0;
                drv.oe_n = 1'b0;
            end
            ST_STOP: begin
                drv.lvl  = '{p: PARK_LVL, n: PARK_LVL};
                drv.oe_p = 1'b1;
                drv.oe_n = 1'b1;
            end
            default: begin
                drv.lvl  = run_lvl;
                drv.oe_p = run_oe;
                drv.oe_n = run_oe;
            end
        endcase
    end

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
#(
    parameter logic PARK_LVL = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pa_clk,
    input  logic               pa_clkb,
    input  logic               pll_clk,
    input  logic               pll_clkb,
    input  logic               ref_clk,
    input  logic               ref_clkb,
    input  logic [SEL_W-1:0]   sel,
    input  logic               pwrdn_n,
    input  logic               stop_n,
    output logic               clk_o,
    output logic               clkb_o,
    output logic               clk_oe,
    output logic               clkb_oe,
    output logic               pll_en,
    output logic [STATE_W-1:0] state_o
);

    op_state_e state_q;
    src_mode_e mode_q;
    drive_t    drv;
    clk_pair_t pa_pair, pll_pair, ref_pair;

    always_comb begin
        pa_pair  = '{p: pa_clk,  n: pa_clkb};
        pll_pair = '{p: pll_clk, n: pll_clkb};
        ref_pair = '{p: ref_clk, n: ref_clkb};
    end

    clkmode_state u_state (
        .clk     (clk),
        .rst     (rst),
        .pwr_n   (pwrdn_n),
        .halt_n  (stop_n),
        .state_q (state_q)
    );

    clkmode_selreg u_selreg (
        .clk     (clk),
        .rst     (rst),
        .load_en (!pwrdn_n),
        .sel_i   (sel),
        .mode_q  (mode_q)
    );

    clkmode_outmux #(
        .PARK_LVL (PARK_LVL)
    ) u_outmux (
        .st   (state_q),
        .md   (mode_q),
        .pa   (pa_pair),
        .pll  (pll_pair),
        .refc (ref_pair),
        .drv  (drv)
    );

    always_comb begin
        clk_o   = drv.lvl.p;
        clkb_o  = drv.lvl.n;
        clk_oe  = drv.oe_p;
        clkb_oe = drv.oe_n;
        pll_en  = drv.pll_on;
        state_o = state_q;
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        state_o == 2'b10 |-> (!clk_oe && !clkb_oe && !pll_en && !clk_o && !clkb_o)); // R8

    AST_STOP_PARK: assert property (@(posedge clk) disable iff (rst)
        state_o == 2'b01 |-> (clk_o == PARK_LVL && clkb_o == PARK_LVL && clk_oe && clkb_oe)); // R9

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'b11); // R3

    AST_OE_PAIRED: assert property (@(posedge clk) disable iff (rst)
        clk_oe == clkb_oe); // R5

endmodule

// File: tb/clkmode_ctrl_tb.sv
`timescale 1ns/1ps
module clkmode_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] cin = '0;
    logic [1:0] sel = '0;
    logic       pwrdn_n = 1'b1;
    logic       stop_n = 1'b1;
    logic       clk_o, clkb_o, clk_oe, clkb_oe, pll_en;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0] exp_mode;
    logic [1:0] exp_state;

    always #4 clk = ~clk;

    clkmode_ctrl u_dut (
        .clk      (clk),
        .rst      (rst),
        .pa_clk   (cin[5]),
        .pa_clkb  (cin[4]),
        .pll_clk  (cin[3]),
        .pll_clkb (cin[2]),
        .ref_clk  (cin[1]),
        .ref_clkb (cin[0]),
        .sel      (sel),
        .pwrdn_n  (pwrdn_n),
        .stop_n   (stop_n),
        .clk_o    (clk_o),
        .clkb_o   (clkb_o),
        .clk_oe   (clk_oe),
        .clkb_oe  (clkb_oe),
        .pll_en   (pll_en),
        .state_o  (state_o)
    );

    // expected {clk_o, clkb_o, clk_oe, clkb_oe, pll_en}
    function automatic logic [4:0] expect_out(input logic [1:0] st, input logic [1:0] md,
                                              input logic [5:0] c);
        logic pll;
        pll = (st != 2'b10) && (md != 2'b11);
        if (st == 2'b10) return 5'b00000;
        if (st == 2'b01) return {1'b0, 1'b0, 1'b1, 1'b1, pll};
        case (md)
            2'b00:   return {c[5], c[4], 1'b1, 1'b1, pll};
            2'b01:   return {1'b0, 1'b0, 1'b0, 1'b0, pll};
            2'b10:   return {c[3], c[2], 1'b1, 1'b1, pll};
            default: return {c[1], c[0], 1'b1, 1'b1, pll};
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] st, input logic [1:0] md);
        if (st == 2'b10) return "R8";
        if (st == 2'b01) return "R9";
        case (md)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_now(input string tag);
        logic [4:0] got, exp;
        got = {clk_o, clkb_o, clk_oe, clkb_oe, pll_en};
        exp = expect_out(exp_state, exp_mode, cin);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: outputs got %b expected %b (state %b mode %b cin %b)",
                     tag, got, exp, exp_state, exp_mode, cin);
        end
    endtask

    task automatic check_state(input string tag);
        checks++;
        if (state_o !== exp_state) begin
            errors++;
            $display("FAIL %s: state_o got %b expected %b", tag, state_o, exp_state);
        end
    endtask

    // drive controls at falling edge, update model at rising edge, sample 2 ns later
    task automatic tick(input logic pd, input logic st, input logic [1:0] s);
        @(negedge clk);
        pwrdn_n = pd;
        stop_n  = st;
        sel     = s;
        @(posedge clk);
        if (!pd) exp_mode = s;
        exp_state = !pd ? 2'b10 : (!st ? 2'b01 : 2'b00);
        #2;
        check_state("R3");
    endtask

    // R10: clock inputs reach outputs within the cycle, no edge needed
    task automatic sweep(input string tag);
        for (int v = 0; v < 64; v++) begin
            cin = v[5:0];
            #1;
            check_now(tag);
        end
        cin = '0;
    endtask

    initial begin
        exp_mode  = 2'b00;
        exp_state = 2'b10;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check_state("R1");
        check_now("R1");
        @(negedge clk);
        rst = 1'b0;

        for (int m = 0; m < 4; m++) begin
            tick(1'b0, 1'b1, m[1:0]);               // load code in power-down
            sweep("R8");
            tick(1'b0, 1'b0, m[1:0]);               // power-down beats clock stop
            sweep("R8");
            tick(1'b1, 1'b1, m[1:0] ^ 2'b11);       // R2: sel change ignored
            check_now("R2");
            sweep(tag_for(exp_state, exp_mode));
            tick(1'b1, 1'b1, m[1:0] ^ 2'b01);
            sweep("R2");
            tick(1'b1, 1'b0, m[1:0] ^ 2'b10);       // clock stop, any code
            sweep("R9");
            tick(1'b1, 1'b1, m[1:0]);
            sweep("R10");
        end

        // R1: reset in mid-run returns to off with code 00
        tick(1'b0, 1'b1, 2'b10);
        tick(1'b1, 1'b1, 2'b10);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        exp_mode  = 2'b00;
        exp_state = 2'b10;
        #2;
        check_state("R1");
        check_now("R1");
        @(negedge clk);
        rst = 1'b0;
        tick(1'b1, 1'b1, 2'b11);
        sweep("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule